// File: doc/BRIEF.md
# Memory Fault Triage Controller

This block decides what happens after a hardware fault trap. A one-cycle fault strobe samples the latched hardware error flags, a status nibble captured from the memory pipe, a software-set policy nibble, the interrupted task number and the task number recorded in the pipe. The block then settles on exactly one of three actions. It can resume the faulted task, it can hand the fault to the emulator at one of two entry addresses, or it can declare a crash with an 8-bit reason code.

Error classes are examined in a fixed order. Each class has its own policy, chosen by policy bits and, for some classes, by which task was running. Every crash shifts its code into a display history register. A crash either raises a debugger break request or parks the block in a halted state that only reset clears. The chosen action, code and target are held with a valid strobe until the consumer acknowledges.

Top module: `fault_triage`

## Requirements
- R1: After reset, act_valid_o, brk_req_o and halted_o are 0 and disp_o is 0.
- R2: Hardware flags are hw_err_i[3] stack overflow, [2] control-store parity, [1] register-file parity and [0] memory-controller error. Bits [3:1] are checked before anything else, and the pipe nibble is consulted only when they are all clear and bit 0 is set. If all four bits are clear, the result is a crash with code 0x10 plus cur_task_i.
- R3: If bit 2 or bit 1 of hw_err_i is set, the result is a crash with code 0x20 plus the whole hw_err_i nibble.
- R4: If stack overflow is the only flag among bits [3:1], the result is a notify when mode_i[3] is 1. Otherwise it is a crash. Both carry code 0x30.
- R5: pipe_stat_i bits are [0] MC2 error A, [1] MC2 error B, [2] H4PE and [3] map-bound. When A and B are both set, the result is a crash with code 0x38, regardless of mode_i.
- R6: On a single MC2 error, the result is a return (code 0) when mode_i[0] is 1. Otherwise it is a crash with code 0x40 plus pipe_task_i.
- R7: With no MC2 error, H4PE takes priority, with or without map-bound. The result is a return only when mode_i[1] is 1 and cur_task_i equals the Ethernet-input task (default 5). Otherwise it is a crash with code 0x50 plus cur_task_i.
- R8: Map-bound alone gives a notify when mode_i[3] is 1, and a crash otherwise. Both carry code 0x60 plus cur_task_i.
- R9: A memory-controller error with none of the four pipe flags set is treated as an MC1 error. The result is a notify when mode_i[3] is 1, and a crash otherwise. Both carry code 0x70 plus pipe_task_i.
- R10: The action encoding is 1 return, 2 notify, 3 crash. A notify targets 0x80 when cur_task_i is 0 and 0x82 otherwise. Return and crash target 0.
- R11: The first cycle a crash is shown, disp_o equals its previous value shifted left 8 bits, OR'd with the crash code.
- R12: Outputs appear one cycle after fault_i. They are held unchanged while act_valid_o is 1 and ack_i is 0. act_valid_o drops the cycle after ack_i. A fault_i that arrives while an action is pending is ignored.
- R13: A crash with mode_i[2] set raises brk_req_o together with act_valid_o, and the block returns to idle after the acknowledge. A crash without it sets halted_o after the acknowledge. From then on, faults are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fault_i | input | 1 | One-cycle fault strobe |
| hw_err_i | input | 4 | Latched hardware error flags |
| pipe_stat_i | input | 4 | Captured memory-pipe status flags |
| mode_i | input | 4 | Fault policy bits |
| cur_task_i | input | 4 | Interrupted task number |
| pipe_task_i | input | 4 | Task number recorded in the pipe word |
| ack_i | input | 1 | Consumer acknowledge |
| act_valid_o | output | 1 | Action pending |
| act_o | output | 2 | Action: 1 return, 2 notify, 3 crash |
| code_o | output | 8 | Crash or notify reason code |
| target_o | output | 8 | Notify entry address |
| brk_req_o | output | 1 | Debugger break request |
| halted_o | output | 1 | Parked after crash |
| disp_o | output | 16 | Crash code display history |

## Verification
The assertions check several properties on every cycle. Pending outputs must hold steady until the acknowledge, the halted state must be sticky, and a break request may appear only with a crash. A notify must point at one of the two entry addresses. The display must shift on each crash, and a double MC2 error must always crash. The bench scenarios are needed for the rest: the exact code arithmetic for each class, the priority between overlapping flags, the task-dependent Ethernet return, and the fact that faults arriving while pending or halted leave no trace.

// File: rtl/fault_triage_pkg.sv
package fault_triage_pkg;
  localparam int TASK_W = 4;
  localparam int CODE_W = 8;
  localparam int TGT_W  = 8;
  localparam int HW_W   = 4;
  localparam int PIPE_W = 4;
  localparam int MODE_W = 4;

  // hardware flag positions
  localparam int HW_MEM = 0;
  localparam int HW_RM  = 1;
  localparam int HW_CS  = 2;
  localparam int HW_STK = 3;
  // pipe flag positions
  localparam int PS_MC2A = 0;
  localparam int PS_MC2B = 1;
  localparam int PS_H4   = 2;
  localparam int PS_MB   = 3;
  // policy bit positions
  localparam int MD_MC2_RET = 0;
  localparam int MD_ETH_RET = 1;
  localparam int MD_DBG     = 2;
  localparam int MD_NOTIFY  = 3;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_RETURN = 2'd1,
    ACT_NOTIFY = 2'd2,
    ACT_CRASH  = 2'd3
  } act_e;

  typedef enum logic [2:0] {
    CL_BRK, CL_PAR, CL_STK, CL_MC2D, CL_MC2, CL_H4, CL_MOB, CL_MC1
  } cls_e;

  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_HALT} st_e;

  typedef struct packed {
    act_e              act;
    logic [CODE_W-1:0] code;
    logic [TGT_W-1:0]  tgt;
  } verdict_t;
endpackage

// File: rtl/fault_class_sel.sv
module fault_class_sel
  import fault_triage_pkg::*;
(
  input  logic [HW_W-1:0]   hw_err_i,
  input  logic [PIPE_W-1:0] pipe_i,
  output cls_e              cls_o
);
  logic grp_hit, par_hit;

  assign grp_hit = hw_err_i[HW_STK] | hw_err_i[HW_CS] | hw_err_i[HW_RM];
  assign par_hit = hw_err_i[HW_CS] | hw_err_i[HW_RM];

  always_comb begin
    if (grp_hit) begin
      cls_o = par_hit ? CL_PAR : CL_STK;
    end else if (hw_err_i[HW_MEM]) begin
      if (pipe_i[PS_MC2A] && pipe_i[PS_MC2B])      cls_o = CL_MC2D;
      else if (pipe_i[PS_MC2A] || pipe_i[PS_MC2B]) cls_o = CL_MC2;
      else if (pipe_i[PS_H4])                      cls_o = CL_H4;
      else if (pipe_i[PS_MB])                      cls_o = CL_MOB;
      else                                         cls_o = CL_MC1;
    end else begin
      cls_o = CL_BRK;
    end
  end
endmodule

// File: rtl/fault_policy.sv
module fault_policy
  import fault_triage_pkg::*;
#(
  parameter logic [TASK_W-1:0] ETH_TASK  = 4'd5,
  parameter logic [TGT_W-1:0]  NOTIFY_A  = 8'h80,
  parameter logic [TGT_W-1:0]  NOTIFY_B  = 8'h82,
  parameter logic [CODE_W-1:0] CODE_BRK  = 8'h10,
  parameter logic [CODE_W-1:0] CODE_PAR  = 8'h20,
  parameter logic [CODE_W-1:0] CODE_STK  = 8'h30,
  parameter logic [CODE_W-1:0] CODE_MC2D = 8'h38,
  parameter logic [CODE_W-1:0] CODE_MC2  = 8'h40,
  parameter logic [CODE_W-1:0] CODE_H4   = 8'h50,
  parameter logic [CODE_W-1:0] CODE_MOB  = 8'h60,
  parameter logic [CODE_W-1:0] CODE_MC1  = 8'h70
) (
  input  cls_e              cls_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [HW_W-1:0]   hw_err_i,
  input  logic [TASK_W-1:0] cur_task_i,
  input  logic [TASK_W-1:0] pipe_task_i,
  output verdict_t          verdict_o
);
  localparam int PAD_T = CODE_W - TASK_W;
  localparam int PAD_H = CODE_W - HW_W;

  logic [CODE_W-1:0] cur_ext, pipe_ext, hw_ext;
  logic [TGT_W-1:0]  ntf_tgt;
  logic              eth_ok;

  assign cur_ext  = {{PAD_T{1'b0}}, cur_task_i};
  assign pipe_ext = {{PAD_T{1'b0}}, pipe_task_i};
  assign hw_ext   = {{PAD_H{1'b0}}, hw_err_i};
  assign ntf_tgt  = (cur_task_i == '0) ? NOTIFY_A : NOTIFY_B;
  assign eth_ok   = mode_i[MD_ETH_RET] && (cur_task_i == ETH_TASK);

  function automatic verdict_t mk(act_e a, logic [CODE_W-1:0] c, logic [TGT_W-1:0] t);
    verdict_t v;
    v.act  = a;
    v.code = c;
    v.tgt  = t;
    return v;
  endfunction

  function automatic verdict_t ntf_or_crash(logic ntf, logic [CODE_W-1:0] c,
                                            logic [TGT_W-1:0] t);
    return ntf ? mk(ACT_NOTIFY, c, t) : mk(ACT_CRASH, c, '0);
  endfunction

  always_comb begin
    unique case (cls_i)
      CL_BRK:  verdict_o = mk(ACT_CRASH, CODE_BRK + cur_ext, '0);
      CL_PAR:  verdict_o = mk(ACT_CRASH, CODE_PAR + hw_ext, '0);
      CL_STK:  verdict_o = ntf_or_crash(mode_i[MD_NOTIFY], CODE_STK, ntf_tgt);
      CL_MC2D: verdict_o = mk(ACT_CRASH, CODE_MC2D, '0);
      CL_MC2:  verdict_o = mode_i[MD_MC2_RET] ? mk(ACT_RETURN, '0, '0)
                                              : mk(ACT_CRASH, CODE_MC2 + pipe_ext, '0);
      CL_H4:   verdict_o = eth_ok ? mk(ACT_RETURN, '0, '0)
                                  : mk(ACT_CRASH, CODE_H4 + cur_ext, '0);
      CL_MOB:  verdict_o = ntf_or_crash(mode_i[MD_NOTIFY], CODE_MOB + cur_ext, ntf_tgt);
      CL_MC1:  verdict_o = ntf_or_crash(mode_i[MD_NOTIFY], CODE_MC1 + pipe_ext, ntf_tgt);
      default: verdict_o = mk(ACT_CRASH, CODE_BRK + cur_ext, '0);
    endcase
  end
endmodule

// File: rtl/crash_display.sv
module crash_display
  import fault_triage_pkg::*;
#(
  parameter int DISP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [DISP_W-1:0] disp_o
);
  logic [DISP_W-1:0] disp_d;

  generate
    if (DISP_W > CODE_W) begin : g_hist
      assign disp_d = {disp_o[DISP_W-CODE_W-1:0], code_i};
    end else begin : g_single
      assign disp_d = code_i[DISP_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      disp_o <= '0;
    else if (shift_i) disp_o <= disp_d;
  end
endmodule

// File: rtl/triage_ctrl.sv
module triage_ctrl
  import fault_triage_pkg::*;
#(
  parameter logic [TGT_W-1:0] NOTIFY_A = 8'h80,
  parameter logic [TGT_W-1:0] NOTIFY_B = 8'h82
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     fault_i,
  input  logic     ack_i,
  input  logic     dbg_i,
  input  verdict_t verdict_i,
  output logic     valid_o,
  output verdict_t verdict_o,
  output logic     brk_req_o,
  output logic     halted_o,
  output logic     shift_o
);
  st_e  st_q;
  logic halt_after_q;
  logic take, is_crash;

  assign take     = (st_q == ST_IDLE) && fault_i;
  assign is_crash = (verdict_i.act == ACT_CRASH);
  assign shift_o  = take && is_crash;
  assign halted_o = (st_q == ST_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      valid_o      <= 1'b0;
      verdict_o    <= '0;
      brk_req_o    <= 1'b0;
      halt_after_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (fault_i) begin
          st_q         <= ST_PEND;
          valid_o      <= 1'b1;
          verdict_o    <= verdict_i;
          brk_req_o    <= is_crash && dbg_i;
          halt_after_q <= is_crash && !dbg_i;
        end
        ST_PEND: if (ack_i) begin
          valid_o   <= 1'b0;
          brk_req_o <= 1'b0;
          st_q      <= halt_after_q ? ST_HALT : ST_IDLE;
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  // R12
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ack_i |=> valid_o && $stable(verdict_o));
  // R13
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && !valid_o);
  // R13
  brk_only_crash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> valid_o && verdict_o.act == ACT_CRASH);
  // R10
  notify_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && verdict_o.act == ACT_NOTIFY |-> verdict_o.tgt == NOTIFY_A || verdict_o.tgt == NOTIFY_B);
endmodule

// File: rtl/fault_triage.sv
module fault_triage
  import fault_triage_pkg::*;
#(
  parameter int                DISP_W    = 16,
  parameter logic [TASK_W-1:0] ETH_TASK  = 4'd5,
  parameter logic [TGT_W-1:0]  NOTIFY_A  = 8'h80,
  parameter logic [TGT_W-1:0]  NOTIFY_B  = 8'h82,
  parameter logic [CODE_W-1:0] CODE_MC2D = 8'h38
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic [HW_W-1:0]   hw_err_i,
  input  logic [PIPE_W-1:0] pipe_stat_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [TASK_W-1:0] cur_task_i,
  input  logic [TASK_W-1:0] pipe_task_i,
  input  logic              ack_i,
  output logic              act_valid_o,
  output logic [1:0]        act_o,
  output logic [CODE_W-1:0] code_o,
  output logic [TGT_W-1:0]  target_o,
  output logic              brk_req_o,
  output logic              halted_o,
  output logic [DISP_W-1:0] disp_o
);
  cls_e     cls;
  verdict_t verdict_c, verdict_q;
  logic     shift;

  fault_class_sel u_cls (
    .hw_err_i (hw_err_i),
    .pipe_i   (pipe_stat_i),
    .cls_o    (cls)
  );

  fault_policy #(
    .ETH_TASK  (ETH_TASK),
    .NOTIFY_A  (NOTIFY_A),
    .NOTIFY_B  (NOTIFY_B),
    .CODE_MC2D (CODE_MC2D)
  ) u_pol (
    .cls_i       (cls),
    .mode_i      (mode_i),
    .hw_err_i    (hw_err_i),
    .cur_task_i  (cur_task_i),
    .pipe_task_i (pipe_task_i),
    .verdict_o   (verdict_c)
  );

  triage_ctrl #(
    .NOTIFY_A (NOTIFY_A),
    .NOTIFY_B (NOTIFY_B)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_i   (fault_i),
    .ack_i     (ack_i),
    .dbg_i     (mode_i[MD_DBG]),
    .verdict_i (verdict_c),
    .valid_o   (act_valid_o),
    .verdict_o (verdict_q),
    .brk_req_o (brk_req_o),
    .halted_o  (halted_o),
    .shift_o   (shift)
  );

  crash_display #(.DISP_W(DISP_W)) u_disp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .code_i  (verdict_c.code),
    .disp_o  (disp_o)
  );

  assign act_o    = verdict_q.act;
  assign code_o   = verdict_q.code;
  assign target_o = verdict_q.tgt;

  // R11
  disp_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_valid_o) && act_o == ACT_CRASH |->
      disp_o == (($past(disp_o) << CODE_W) | DISP_W'(code_o)));
  // R5
  mc2_double_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_valid_o) && $past(hw_err_i == 4'b0001 && pipe_stat_i[PS_MC2A] && pipe_stat_i[PS_MC2B]) |->
      act_o == ACT_CRASH && code_o == CODE_MC2D);
endmodule

// File: tb/fault_triage_tb.sv
module fault_triage_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fault = 1'b0, ack = 1'b0;
  logic [3:0] hw = '0, pipe = '0, mode = '0, cur = '0, ptask = '0;
  logic       valid, brk, halted;
  logic [1:0] act;
  logic [7:0] code, tgt;
  logic [15:0] disp;
  logic [15:0] disp_exp = '0;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fault_triage u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(fault), .hw_err_i(hw),
    .pipe_stat_i(pipe), .mode_i(mode), .cur_task_i(cur), .pipe_task_i(ptask),
    .ack_i(ack), .act_valid_o(valid), .act_o(act), .code_o(code),
    .target_o(tgt), .brk_req_o(brk), .halted_o(halted), .disp_o(disp)
  );

  // {req, hw, pipe, mode, cur, ptask, act, code, tgt}
  localparam int NV = 17;
  localparam logic [41:0] VEC [NV] = '{
    {4'd2,  4'b0000, 4'b0000, 4'b0100, 4'd3, 4'd0,  2'd3, 8'h13, 8'h00}, // R2 breakpoint
    {4'd3,  4'b0100, 4'b0000, 4'b0100, 4'd1, 4'd0,  2'd3, 8'h24, 8'h00}, // R3
    {4'd3,  4'b1011, 4'b1111, 4'b0100, 4'd1, 4'd0,  2'd3, 8'h2B, 8'h00}, // R3 over pipe
    {4'd4,  4'b1000, 4'b0000, 4'b1100, 4'd0, 4'd0,  2'd2, 8'h30, 8'h80}, // R4 notify
    {4'd4,  4'b1000, 4'b0000, 4'b0100, 4'd2, 4'd0,  2'd3, 8'h30, 8'h00}, // R4 crash
    {4'd5,  4'b0001, 4'b0111, 4'b0111, 4'd5, 4'd3,  2'd3, 8'h38, 8'h00}, // R5
    {4'd6,  4'b0001, 4'b0001, 4'b0101, 4'd3, 4'd3,  2'd1, 8'h00, 8'h00}, // R6 return
    {4'd6,  4'b0001, 4'b0010, 4'b0100, 4'd3, 4'd9,  2'd3, 8'h49, 8'h00}, // R6 crash
    {4'd7,  4'b0001, 4'b0100, 4'b0110, 4'd5, 4'd1,  2'd1, 8'h00, 8'h00}, // R7 return
    {4'd7,  4'b0001, 4'b1100, 4'b0110, 4'd5, 4'd1,  2'd1, 8'h00, 8'h00}, // R7 with map-bound
    {4'd7,  4'b0001, 4'b0100, 4'b0100, 4'd5, 4'd1,  2'd3, 8'h55, 8'h00}, // R7 mode off
    {4'd7,  4'b0001, 4'b0100, 4'b0110, 4'd6, 4'd1,  2'd3, 8'h56, 8'h00}, // R7 wrong task
    {4'd8,  4'b0001, 4'b1000, 4'b1100, 4'd7, 4'd1,  2'd2, 8'h67, 8'h82}, // R8 notify
    {4'd8,  4'b0001, 4'b1000, 4'b0100, 4'd7, 4'd1,  2'd3, 8'h67, 8'h00}, // R8 crash
    {4'd9,  4'b0001, 4'b0000, 4'b1100, 4'd0, 4'd2,  2'd2, 8'h72, 8'h80}, // R9 notify
    {4'd9,  4'b0001, 4'b0000, 4'b0100, 4'd4, 4'd15, 2'd3, 8'h7F, 8'h00}, // R9 crash
    {4'd10, 4'b1000, 4'b0000, 4'b1100, 4'd9, 4'd0,  2'd2, 8'h30, 8'h82}  // R10 target B
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] actual, input logic [31:0] expect_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, actual, expect_v);
    end
  endtask

  task automatic fire(input logic [3:0] h, p, m, c, pt);
    @(negedge clk);
    hw = h; pipe = p; mode = m; cur = c; ptask = pt; fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL R0 watchdog: actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(valid == 0, 1, "valid", valid, 0);
    chk(disp == 0, 1, "disp", disp, 0);
    chk(brk == 0 && halted == 0, 1, "brk/halt", {brk, halted}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      fire(v[37:34], v[33:30], v[29:26], v[25:22], v[21:18]);
      if (v[17:16] == 2'd3) disp_exp = {disp_exp[7:0], v[15:8]};
      chk(valid == 1, int'(v[41:38]), "valid", valid, 1);
      chk(act == v[17:16], int'(v[41:38]), "act", act, v[17:16]);
      chk(code == v[15:8], int'(v[41:38]), "code", code, v[15:8]);
      chk(tgt == v[7:0], int'(v[41:38]), "target", tgt, v[7:0]);
      chk(disp == disp_exp, 11, "disp", disp, disp_exp); // R11
      do_ack();
      chk(valid == 0, 12, "valid after ack", valid, 0);
    end

    // R12 hold while unacked, ignore second fault
    fire(4'b0001, 4'b0010, 4'b0100, 4'd0, 4'd3); // crash 0x43
    disp_exp = {disp_exp[7:0], 8'h43};
    repeat (2) @(negedge clk);
    hw = 4'b0000; cur = 4'd8; fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
    @(negedge clk);
    chk(valid == 1 && code == 8'h43, 12, "held code", code, 8'h43);
    chk(disp == disp_exp, 12, "disp untouched", disp, disp_exp);
    // R13 debugger break request with crash
    chk(brk == 1, 13, "brk_req", brk, 1);
    do_ack();
    chk(brk == 0 && halted == 0, 13, "idle after dbg crash", {brk, halted}, 0);

    // R13 non-debugger crash halts
    fire(4'b0000, 4'b0000, 4'b0000, 4'd2, 4'd0); // crash 0x12
    disp_exp = {disp_exp[7:0], 8'h12};
    chk(brk == 0 && code == 8'h12, 13, "no brk", {brk, code}, 9'h012);
    do_ack();
    chk(halted == 1, 13, "halted", halted, 1);
    fire(4'b1000, 4'b0000, 4'b1100, 4'd0, 4'd0);
    @(negedge clk);
    chk(valid == 0 && halted == 1, 13, "fault ignored when halted", valid, 0);
    chk(disp == disp_exp, 13, "disp frozen", disp, disp_exp);

    // R1 reset clears halt and display
    rst_n = 1'b0;
    @(negedge clk);
    chk(halted == 0 && disp == 0, 1, "reset clears", {halted, disp}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule